// File: doc/BRIEF.md
# Inbound Address Remap Table

The block holds a small table of inbound translation windows. Each window claims a power-of-two region of a 64-bit address space, aligned to at least 4 KB. It redirects any address in that region to a programmed 64-bit destination base, keeping the offset inside the region. Each window also carries a destination interface tag.

Software fills the table through a simple word-wide register port. Each window has a fixed 8-word stride. Address bits [5:3] select the window and bits [2:0] select the word in it:

| Word | Content |
|------|---------|
| 0 | Source address bits [31:12] in [31:12], size code in [6:1], enable in [0] |
| 1 | Source address bits [63:32] |
| 2 | Destination base bits [31:0] |
| 3 | Destination base bits [63:32] |
| 4 | Destination tag in bits [3:0] |

Addresses arrive on a valid/ready lookup stream. Results leave on a second valid/ready stream, one register stage later.

Back-pressure is handled as follows:
- The input is accepted on any clock edge where `lk_valid` and `lk_ready` are both high.
- `lk_ready` is high whenever the result stage is empty or is being drained in the same cycle.
- A result that is offered but not taken stays unchanged until `rs_ready` is seen high.

Top module: `ib_addr_remap`

## Requirements
- R1: After reset, every window is disabled, all table words read back as zero, `rs_valid` is 0 and `lk_ready` is 1.
- R2: Writes to words 0 to 4 of a window are read back unchanged on `cfg_rdata`. Words 5 to 7 read as zero and writes to them change nothing.
- R3: An address hits a window only when that window's enable bit (word 0 bit 0) is 1 and all address bits at or above the window size equal the programmed source address bits.
- R4: On a hit, the result is the destination base with its bits below the window size replaced by the same bits of the input address.
- R5: A size code n gives a window of 2^(n+1) bytes. Codes below 11 behave as 11, which is 4 KB.
- R6: When several windows hit, the one with the lowest index supplies the result.
- R7: When no window hits, `rs_hit` is 0, `rs_tid` is 0 and `rs_addr` equals the input address.
- R8: On a hit, `rs_tid` equals bits [3:0] of the winning window's word 4.
- R9: A lookup accepted on one clock edge appears on the result port after that edge. `lk_ready` is `!rs_valid || rs_ready`. A result that is stalled holds all of its fields stable.
- R10: Size code 63 makes a window cover the whole 64-bit space, so it hits every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Word address: window index [5:3], word select [2:0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the word at `cfg_addr` (combinational) |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 64 | Address to translate |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_addr | output | 64 | Translated or passed-through address |
| rs_hit | output | 1 | A window matched |
| rs_tid | output | 4 | Destination tag of the winning window |

## Verification
The bound checker watches the stream rules on every cycle:
- a stalled result stays stable;
- an accepted lookup yields a result;
- `lk_ready` is high whenever the result stage is empty;
- a miss passes the captured address through with a zero tag;
- a hit keeps the low 12 offset bits of the address.

The size decoding, the clamping of small codes, priority between overlapping windows, disabled windows and the whole-space window depend on table contents. Only the bench scenarios can show those, since they compare translated addresses against values worked out by hand.

// File: rtl/ib_remap_pkg.sv
package ib_remap_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 2 * WORD_W;
  localparam int PAGE_SHIFT = 12;
  localparam int CODE_W     = 6;
  localparam int CODE_LSB   = 1;
  localparam int MIN_CODE   = PAGE_SHIFT - 1;
  localparam int WSEL_W     = 3;

  typedef enum logic [WSEL_W-1:0] {
    WSEL_SRC_LO    = 3'd0,
    WSEL_SRC_HI    = 3'd1,
    WSEL_DST_LO    = 3'd2,
    WSEL_DST_HI    = 3'd3,
    WSEL_DST_PARAM = 3'd4
  } wsel_e;

  typedef struct packed {
    logic [WORD_W-1:0] src_lo;
    logic [WORD_W-1:0] src_hi;
    logic [WORD_W-1:0] dst_lo;
    logic [WORD_W-1:0] dst_hi;
    logic [WORD_W-1:0] dst_param;
  } win_regs_t;
endpackage

// File: rtl/ib_remap_regs.sv
module ib_remap_regs
  import ib_remap_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int CFG_AW  = $clog2(NUM_WIN) + WSEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [WORD_W-1:0]         cfg_wdata,
  output logic [WORD_W-1:0]         cfg_rdata,
  output win_regs_t [NUM_WIN-1:0]   tbl_o
);
  localparam int IDX_W = CFG_AW - WSEL_W;

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] sel;

  assign idx = cfg_addr[CFG_AW-1:WSEL_W];
  assign sel = cfg_addr[WSEL_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit_idx;
    assign hit_idx = cfg_we && (idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_o[w] <= '0;
      end else if (hit_idx) begin
        case (sel)
          WSEL_SRC_LO:    tbl_o[w].src_lo    <= cfg_wdata;
          WSEL_SRC_HI:    tbl_o[w].src_hi    <= cfg_wdata;
          WSEL_DST_LO:    tbl_o[w].dst_lo    <= cfg_wdata;
          WSEL_DST_HI:    tbl_o[w].dst_hi    <= cfg_wdata;
          WSEL_DST_PARAM: tbl_o[w].dst_param <= cfg_wdata;
          default:        ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (idx == IDX_W'(w)) begin
        case (sel)
          WSEL_SRC_LO:    cfg_rdata = tbl_o[w].src_lo;
          WSEL_SRC_HI:    cfg_rdata = tbl_o[w].src_hi;
          WSEL_DST_LO:    cfg_rdata = tbl_o[w].dst_lo;
          WSEL_DST_HI:    cfg_rdata = tbl_o[w].dst_hi;
          WSEL_DST_PARAM: cfg_rdata = tbl_o[w].dst_param;
          default:        cfg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ib_remap_window.sv
module ib_remap_window
  import ib_remap_pkg::*;
#(
  parameter int TID_W = 4
) (
  input  win_regs_t          regs_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic [ADDR_W-1:0]  xlat_o,
  output logic [TID_W-1:0]   tid_o
);
  logic [CODE_W-1:0] code_raw;
  logic [CODE_W-1:0] code_eff;
  logic [CODE_W:0]   span_log2;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] src_base;
  logic [ADDR_W-1:0] dst_base;

  assign code_raw  = regs_i.src_lo[CODE_LSB +: CODE_W];
  assign code_eff  = (code_raw < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code_raw;
  assign span_log2 = {1'b0, code_eff} + 1'b1;
  // Ones above the window size; all zeros when the window spans 2^64
  assign keep_mask = {ADDR_W{1'b1}} << span_log2;
  assign src_base  = {regs_i.src_hi, regs_i.src_lo[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign dst_base  = {regs_i.dst_hi, regs_i.dst_lo};

  assign hit_o  = regs_i.src_lo[0] && (((addr_i ^ src_base) & keep_mask) == '0);
  assign xlat_o = (dst_base & keep_mask) | (addr_i & ~keep_mask);
  assign tid_o  = regs_i.dst_param[TID_W-1:0];
endmodule

// File: rtl/ib_remap_pick.sv
module ib_remap_pick
  import ib_remap_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int TID_W   = 4
) (
  input  logic [NUM_WIN-1:0]              hit_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlat_i,
  input  logic [NUM_WIN-1:0][TID_W-1:0]   tid_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic                            any_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic [TID_W-1:0]                tid_o
);
  always_comb begin
    any_o  = 1'b0;
    addr_o = addr_i;
    tid_o  = '0;
    // Walk from the top so the lowest index is applied last and wins
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        any_o  = 1'b1;
        addr_o = xlat_i[w];
        tid_o  = tid_i[w];
      end
    end
  end
endmodule

// File: rtl/ib_addr_remap.sv
module ib_addr_remap
  import ib_remap_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int TID_W   = 4,
  parameter int CFG_AW  = $clog2(NUM_WIN) + WSEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                rs_valid,
  input  logic                rs_ready,
  output logic [ADDR_W-1:0]   rs_addr,
  output logic                rs_hit,
  output logic [TID_W-1:0]    rs_tid
);
  win_regs_t [NUM_WIN-1:0]             tbl;
  logic [NUM_WIN-1:0]                  win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]      win_xlat;
  logic [NUM_WIN-1:0][TID_W-1:0]       win_tid;
  logic                                pick_any;
  logic [ADDR_W-1:0]                   pick_addr;
  logic [TID_W-1:0]                    pick_tid;

  ib_remap_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tbl_o     (tbl)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    ib_remap_window #(.TID_W(TID_W)) u_win (
      .regs_i (tbl[w]),
      .addr_i (lk_addr),
      .hit_o  (win_hit[w]),
      .xlat_o (win_xlat[w]),
      .tid_o  (win_tid[w])
    );
  end

  ib_remap_pick #(.NUM_WIN(NUM_WIN), .TID_W(TID_W)) u_pick (
    .hit_i  (win_hit),
    .xlat_i (win_xlat),
    .tid_i  (win_tid),
    .addr_i (lk_addr),
    .any_o  (pick_any),
    .addr_o (pick_addr),
    .tid_o  (pick_tid)
  );

  assign lk_ready = !rs_valid || rs_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_addr  <= '0;
      rs_hit   <= 1'b0;
      rs_tid   <= '0;
    end else if (lk_ready) begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_addr <= pick_addr;
        rs_hit  <= pick_any;
        rs_tid  <= pick_tid;
      end
    end
  end
endmodule

// File: rtl/ib_remap_chk.sv
module ib_remap_chk #(
  parameter int ADDR_W = 64,
  parameter int TID_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [ADDR_W-1:0] rs_addr,
  input logic              rs_hit,
  input logic [TID_W-1:0]  rs_tid
);
  logic [ADDR_W-1:0] taken_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_addr <= '0;
    else if (lk_valid && lk_ready) taken_addr <= lk_addr;
  end

  // R9
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_addr) && $stable(rs_hit) && $stable(rs_tid));

  // R9
  accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> lk_ready);

  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_addr == taken_addr && rs_tid == '0);

  // R4
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_hit |-> rs_addr[11:0] == taken_addr[11:0]);
endmodule

bind ib_addr_remap ib_remap_chk #(.ADDR_W(ib_remap_pkg::ADDR_W), .TID_W(TID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .lk_addr  (lk_addr),
  .rs_valid (rs_valid),
  .rs_ready (rs_ready),
  .rs_addr  (rs_addr),
  .rs_hit   (rs_hit),
  .rs_tid   (rs_tid)
);

// File: tb/ib_addr_remap_bench.sv
module ib_addr_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [63:0] lk_addr = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic [63:0] rs_addr;
  logic        rs_hit;
  logic [3:0]  rs_tid;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ib_addr_remap u_ib_addr_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_addr(rs_addr), .rs_hit(rs_hit), .rs_tid(rs_tid)
  );

  // {lookup, expected addr, expected hit, expected tag}
  localparam int NV = 12;
  localparam logic [132:0] VEC [NV] = '{
    {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 1'b1, 4'd1},
    {64'h0000_0000_BFFF_FFFC, 64'h0000_0000_3FFF_FFFC, 1'b1, 4'd1},
    {64'h0000_0000_C000_0004, 64'h0000_0000_4000_0004, 1'b1, 4'd2},
    {64'h0000_0001_8000_0000, 64'h0000_0001_8000_0000, 1'b0, 4'd0},
    {64'h0000_0012_3456_7ABC, 64'h0000_ABCD_0000_1ABC, 1'b1, 4'd3},
    {64'h0000_0012_3400_0010, 64'h0000_0000_5000_0010, 1'b1, 4'd4},
    {64'h0000_0012_3456_8000, 64'h0000_0000_5056_8000, 1'b1, 4'd4},
    {64'h0000_0000_0000_3ABC, 64'h0000_0000_0000_7ABC, 1'b1, 4'd5},
    {64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 1'b0, 4'd0},
    {64'h9000_0000_0000_0010, 64'h9000_0000_0000_0010, 1'b0, 4'd0},
    {64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b0, 4'd0},
    {64'h0000_0012_34FF_FFFF, 64'h0000_0000_50FF_FFFF, 1'b1, 4'd4}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int win, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'((win << 3) | word); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input int win, input int word, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = 6'((win << 3) | word);
    #1;
    chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic setwin(input int win, input logic [63:0] src, input int code, input bit en,
                        input logic [63:0] dst, input logic [3:0] tid);
    wr(win, 0, {src[31:12], 5'd0, 6'(code), en});
    wr(win, 1, src[63:32]);
    wr(win, 2, dst[31:0]);
    wr(win, 3, dst[63:32]);
    wr(win, 4, {28'd0, tid});
  endtask

  task automatic look(input logic [63:0] a, input logic [63:0] ea, input bit eh,
                      input logic [3:0] et, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid == 1'b1, {req, " valid"}, 64'(rs_valid), 64'd1);
    chk(rs_addr == ea, {req, " addr"}, rs_addr, ea);
    chk(rs_hit == eh && rs_tid == et, {req, " hit/tag"}, {59'd0, rs_hit, rs_tid}, {59'd0, eh, et});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rs_valid == 1'b0 && lk_ready == 1'b1, "R1 outputs", {62'd0, rs_valid, lk_ready}, 64'd1);
    rd_chk(0, 0, 32'd0, "R1 table word");
    rst_n = 1'b1;
    look(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 4'd0, "R1 R7 empty table miss");

    setwin(0, 64'h8000_0000, 29, 1'b1, 64'h0, 4'd1);
    setwin(1, 64'hC000_0000, 29, 1'b1, 64'h4000_0000, 4'd2);
    setwin(2, 64'h12_3456_7000, 11, 1'b1, 64'hABCD_0000_1000, 4'd3);
    setwin(3, 64'h12_3400_0000, 23, 1'b1, 64'h5000_0000, 4'd4);
    setwin(4, 64'h3000, 5, 1'b1, 64'h7000, 4'd5);
    setwin(5, 64'h9000_0000_0000_0000, 31, 1'b0, 64'h0, 4'd6);

    // R2 readback and unused words
    rd_chk(2, 0, 32'h3456_7017, "R2 word0");
    rd_chk(2, 3, 32'h0000_ABCD, "R2 word3");
    rd_chk(1, 4, 32'h0000_0002, "R2 word4");
    wr(1, 5, 32'hFFFF_FFFF);
    rd_chk(1, 5, 32'h0, "R2 unused word");

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][132:69], VEC[i][68:5], VEC[i][4], VEC[i][3:0], "R3 R4 R5 R6 R7 R8 vector");
    end

    // R2 write to unused word did not disturb window 1
    look(64'hC000_0004, 64'h4000_0004, 1'b1, 4'd2, "R2 window intact");

    // R9 stall: result held while rs_ready low
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_addr = 64'hC000_0008;
    @(negedge clk);
    lk_addr = 64'h8000_0000;
    chk(rs_valid && !lk_ready && rs_addr == 64'h4000_0008, "R9 stall capture", rs_addr, 64'h4000_0008);
    @(negedge clk);
    chk(rs_valid && !lk_ready && rs_addr == 64'h4000_0008 && rs_tid == 4'd2, "R9 stall hold", rs_addr, 64'h4000_0008);
    rs_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid && rs_addr == 64'h0 && rs_tid == 4'd1, "R9 drain and refill", rs_addr, 64'h0);
    @(negedge clk);
    chk(!rs_valid, "R9 empty after drain", 64'(rs_valid), 64'd0);

    // R10 whole-space window; R6 lower windows still win
    setwin(7, 64'h0, 63, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd7);
    look(64'h5555_0000_1234_5678, 64'h5555_0000_1234_5678, 1'b1, 4'd7, "R10 any address");
    look(64'h4000, 64'h4000, 1'b1, 4'd7, "R10 former miss");
    look(64'h8000_0010, 64'h10, 1'b1, 4'd1, "R6 priority over whole-space");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule